// File: doc/BRIEF.md
# Codec Control-Word Writer (I2C, write-only)

This block is an I2C bus master that programs an audio codec whose registers hold 9 data bits behind a 7-bit register index. The host hands over one register index and one 9-bit value through a valid/ready handshake. The block then emits a complete write frame on open-drain SCL and SDA: a START, the device byte, two payload bytes and a STOP.

The 16-bit control word is the index followed by the value. The bus carries it as two bytes, so bit 8 of the value rides in the lowest bit of the first payload byte. The block checks the slave's acknowledge after every byte. It reports completion with a one-cycle pulse and flags a missing acknowledge. It only writes. There is no read path, no clock stretching and no arbitration.

The sequencer has five states. **IDLE** accepts a request and moves to **START** (take). **START** moves to **SEND** after four quarter-periods (lead-in). **SEND** shifts eight bits and moves to **ACKCHK** (byte-out). **ACKCHK** moves back to **SEND** when the slave acknowledged and bytes remain (next-byte). It moves to **STOP** after the last byte or on a NACK (wrap-up). **STOP** returns to **IDLE** and pulses done (release).

Top module: `codec_ctl_writer`

## Requirements
- R1: After reset, and whenever busy is low, both line drivers are released (scl_drive_low = 0, sda_drive_low = 0), req_ready is 1 and nack_err is 0.
- R2: The first byte after START is 0x34: device address 0011010 followed by write bit 0.
- R3: The second byte is {reg_index[6:0], data[8]}. For example, index 0x29 with data 0x008 gives 0x52.
- R4: The third byte is data[7:0].
- R5: Bytes go out MSB first. The ninth SCL pulse of each byte is an acknowledge slot, in which the master releases SDA and samples it (low = ACK, high = NACK).
- R6: SDA changes only while SCL is low, except for one START (SDA falls while SCL is high) and one STOP (SDA rises while SCL is high) per transfer. SCL and SDA drivers never change in the same cycle.
- R7: The SCL period is 4*Q clock cycles, where Q = CLK_HZ/(4*SCL_HZ).
- R8: A NACK on any byte ends the transfer with STOP, sends no further byte, and completes with nack_err = 1. A fully acknowledged transfer completes with nack_err = 0.
- R9: nack_err holds its value until the next accepted request, and it is cleared in the cycle after that acceptance.
- R10: busy rises in the cycle after acceptance and stays high until STOP completes. req_ready equals !busy, and a request presented while busy is ignored and causes no further frame.
- R11: done is a single-cycle pulse at the end of every transfer, and busy is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can take a request |
| req_reg | input | 7 | Codec register index |
| req_data | input | 9 | Value to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| nack_err | output | 1 | Last transfer saw a NACK |
| scl_drive_low | output | 1 | Pull SCL low (released when 0) |
| sda_drive_low | output | 1 | Pull SDA low (released when 0) |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The hardest situations to reach are the ACKCHK-to-STOP exit on the second or third byte and a request arriving in the middle of a frame. From the master's side, both look like ordinary traffic. The bench attaches a small slave model that decodes the wire and withholds its acknowledge on one chosen byte, so each NACK position is reached in turn. It also raises req_valid for one cycle deep inside a frame and then watches the wire to confirm that no second frame follows.

// File: rtl/ccw_pkg.sv
package ccw_pkg;
    localparam int unsigned IDX_W         = 7;
    localparam int unsigned VAL_W         = 9;
    localparam int unsigned CTRL_W        = IDX_W + VAL_W;
    localparam int unsigned PAYLOAD_BYTES = CTRL_W / 8;
    localparam int unsigned FRAME_BYTES   = PAYLOAD_BYTES + 1;
    localparam int unsigned BYTE_IDX_W    = $clog2(FRAME_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_SEND   = 3'd2,
        ST_ACKCHK = 3'd3,
        ST_STOP   = 3'd4
    } ccw_state_e;
endpackage

// File: rtl/ccw_quarter_timer.sv
module ccw_quarter_timer #(
    parameter int unsigned QDIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == CW'(QDIV - 1));
    assign tick   = run && at_end;

    // R7: one tick per quarter of an SCL period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/ccw_frame_pack.sv
module ccw_frame_pack
    import ccw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h1A
) (
    input  logic [IDX_W-1:0]                reg_idx,
    input  logic [VAL_W-1:0]                reg_val,
    output logic [FRAME_BYTES-1:0][7:0]     frame
);
    logic [CTRL_W-1:0] ctrl_word;

    // R3/R4: index sits on top of the value, so value bit 8 lands in the
    // lowest bit of the first payload byte
    assign ctrl_word = {reg_idx, reg_val};

    // R2: device byte with write bit 0
    assign frame[0] = {DEV_ADDR, 1'b0};

    for (genvar g = 0; g < PAYLOAD_BYTES; g++) begin : g_pay
        assign frame[g + 1] = ctrl_word[CTRL_W - 1 - 8 * g -: 8];
    end
endmodule

// File: rtl/ccw_seq.sv
module ccw_seq
    import ccw_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         accept,
    input  logic                         tick,
    input  logic [FRAME_BYTES-1:0][7:0]  frame,
    input  logic                         sda_in,
    output logic                         busy,
    output logic                         done,
    output logic                         nack_err,
    output logic                         scl_drive_low,
    output logic                         sda_drive_low
);
    ccw_state_e              state_q, state_d;
    logic [1:0]              quarter_q;
    logic [2:0]              bit_q;
    logic [BYTE_IDX_W-1:0]   byte_q;
    logic                    nack_q;
    logic                    done_q;
    logic                    err_q;
    logic                    scl_low_q;
    logic                    sda_low_q;
    logic                    q_end;
    logic                    last_byte;
    logic                    cur_bit;

    assign q_end     = tick && (quarter_q == 2'd3);
    assign last_byte = (byte_q == BYTE_IDX_W'(FRAME_BYTES - 1));
    assign cur_bit   = frame[byte_q][bit_q];

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_START;
            ST_START:  if (q_end) state_d = ST_SEND;
            ST_SEND:   if (q_end && (bit_q == 3'd0)) state_d = ST_ACKCHK;
            ST_ACKCHK: if (q_end) state_d = (nack_q || last_byte) ? ST_STOP : ST_SEND; // R8
            ST_STOP:   if (q_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            quarter_q <= 2'd0;
            bit_q     <= 3'd7;
            byte_q    <= '0;
            nack_q    <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= 1'b0;
            if (state_q == ST_IDLE) begin
                quarter_q <= 2'd0;
            end else if (tick) begin
                quarter_q <= quarter_q + 2'd1;
            end
            if (state_q == ST_IDLE && accept) begin
                byte_q <= '0;
                bit_q  <= 3'd7;
                nack_q <= 1'b0;
                err_q  <= 1'b0;   // R9
            end
            if (state_q == ST_SEND && q_end && bit_q != 3'd0) begin
                bit_q <= bit_q - 3'd1;   // R5 MSB first
            end
            if (state_q == ST_ACKCHK && tick && quarter_q == 2'd2) begin
                nack_q <= sda_in;        // R5 sample in the high half
            end
            if (state_q == ST_ACKCHK && q_end && state_d == ST_SEND) begin
                byte_q <= byte_q + BYTE_IDX_W'(1);
                bit_q  <= 3'd7;
            end
            if (state_q == ST_STOP && q_end) begin
                done_q <= 1'b1;          // R11
                err_q  <= nack_q;        // R8
            end
        end
    end

    // line drivers: registered, SCL and SDA never move on the same edge (R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_low_q <= 1'b0;
            sda_low_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    scl_low_q <= 1'b0;
                    sda_low_q <= 1'b0;
                end
                ST_START: begin
                    scl_low_q <= (quarter_q == 2'd3);
                    sda_low_q <= (quarter_q != 2'd0);
                end
                ST_SEND: begin
                    scl_low_q <= (quarter_q < 2'd2);
                    if (quarter_q != 2'd0) sda_low_q <= ~cur_bit;
                end
                ST_ACKCHK: begin
                    scl_low_q <= (quarter_q < 2'd2);
                    if (quarter_q != 2'd0) sda_low_q <= 1'b0;
                end
                ST_STOP: begin
                    scl_low_q <= (quarter_q < 2'd2);
                    if (quarter_q == 2'd1 || quarter_q == 2'd2) sda_low_q <= 1'b1;
                    else if (quarter_q == 2'd3) sda_low_q <= 1'b0;
                end
                default: begin
                    scl_low_q <= 1'b0;
                    sda_low_q <= 1'b0;
                end
            endcase
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign done          = done_q;
    assign nack_err      = err_q;
    assign scl_drive_low = scl_low_q;
    assign sda_drive_low = sda_low_q;
endmodule

// File: rtl/codec_ctl_writer.sv
module codec_ctl_writer
    import ccw_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned SCL_HZ   = 100_000,
    parameter logic [6:0]  DEV_ADDR = 7'h1A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IDX_W-1:0] req_reg,
    input  logic [VAL_W-1:0] req_data,
    output logic             busy,
    output logic             done,
    output logic             nack_err,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    input  logic             sda_in
);
    localparam int unsigned QDIV = CLK_HZ / (4 * SCL_HZ);

    logic                        accept;
    logic                        tick;
    logic [IDX_W-1:0]            idx_q;
    logic [VAL_W-1:0]            val_q;
    logic                        sda_meta_q, sda_sync_q;
    logic [FRAME_BYTES-1:0][7:0] frame;

    assign req_ready = !busy;   // R10
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            val_q <= '0;
        end else if (accept) begin
            idx_q <= req_reg;
            val_q <= req_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_meta_q <= 1'b1;
            sda_sync_q <= 1'b1;
        end else begin
            sda_meta_q <= sda_in;
            sda_sync_q <= sda_meta_q;
        end
    end

    ccw_quarter_timer #(.QDIV(QDIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    ccw_frame_pack #(.DEV_ADDR(DEV_ADDR)) u_pack (
        .reg_idx (idx_q),
        .reg_val (val_q),
        .frame   (frame)
    );

    ccw_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept        (accept),
        .tick          (tick),
        .frame         (frame),
        .sda_in        (sda_sync_q),
        .busy          (busy),
        .done          (done),
        .nack_err      (nack_err),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low)
    );
endmodule

// File: rtl/ccw_checker.sv
module ccw_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic done,
    input logic nack_err,
    input logic scl_drive_low,
    input logic sda_drive_low
);
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_drive_low && !sda_drive_low)); // R1

    AST_NO_JOINT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(scl_drive_low) && !$stable(sda_drive_low))); // R6

    AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_drive_low) && !scl_drive_low && $past(!scl_drive_low)) |-> busy); // R6

    AST_ERR_SET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_err) |-> done); // R8

    AST_ERR_CLEAR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nack_err) |-> $past(req_valid && req_ready)); // R9

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && req_ready)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
endmodule

bind codec_ctl_writer ccw_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .busy          (busy),
    .done          (done),
    .nack_err      (nack_err),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low)
);

// File: tb/codec_ctl_writer_tb.sv
module codec_ctl_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int SCL_HZ     = 100_000;
    localparam int QDIV       = CLK_HZ / (4 * SCL_HZ);
    localparam longint SCL_T  = 4 * QDIV * CLK_PERIOD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [6:0] req_reg = '0;
    logic [8:0] req_data = '0;
    logic       busy, done, nack_err, scl_low, sda_low;
    logic       slv_low = 1'b0;
    logic       scl_line, sda_line;

    assign scl_line = !scl_low;
    assign sda_line = !(sda_low || slv_low);

    codec_ctl_writer #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_reg(req_reg), .req_data(req_data), .busy(busy), .done(done),
        .nack_err(nack_err), .scl_drive_low(scl_low), .sda_drive_low(sda_low),
        .sda_in(sda_line)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    int         bitcnt = 0, rx_n = 0, start_cnt = 0, stop_cnt = 0, nack_at = 9;
    bit         in_frame = 0;
    logic [7:0] shreg = '0;
    logic [7:0] rx_b [0:7];
    longint     last_rise = 0, prev_rise = 0, period_meas = 0;

    always @(negedge sda_line) if (scl_line === 1'b1) begin
        start_cnt++; in_frame = 1; bitcnt = 0;
    end
    always @(posedge sda_line) if (scl_line === 1'b1) begin
        stop_cnt++; in_frame = 0; slv_low = 0;
    end
    always @(posedge scl_line) begin
        prev_rise = last_rise;
        last_rise = $time;
        if (in_frame && bitcnt < 8) begin
            shreg = {shreg[6:0], sda_line};
            bitcnt++;
            if (bitcnt == 8 && rx_n < 8) begin
                rx_b[rx_n] = shreg;
                rx_n++;
                if (rx_n == 1) period_meas = last_rise - prev_rise;
            end
        end
    end
    always @(negedge scl_line) if (in_frame) begin
        if (bitcnt == 8) begin
            slv_low = (rx_n - 1 != nack_at);
            bitcnt = 9;
        end else if (bitcnt == 9) begin
            slv_low = 0;
            bitcnt = 0;
        end
    end

    // ---------------- transfer driver ----------------
    int done_cnt;
    bit busy_at_done, err_at_done, busy_after_take, err_after_take, ready_while_busy;

    task automatic run_xfer(input logic [6:0] r, input logic [8:0] d, input int nk, input bit intrude);
        rx_n = 0; start_cnt = 0; stop_cnt = 0; nack_at = nk; done_cnt = 0;
        ready_while_busy = 0; busy_at_done = 1; err_at_done = 0;
        @(negedge clk);
        req_reg = r; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        busy_after_take = busy;
        err_after_take  = nack_err;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (intrude && i == 200) begin
                req_valid = 1'b1; req_reg = ~r; req_data = ~d;
            end else begin
                req_valid = 1'b0;
            end
            if (busy && req_ready) ready_while_busy = 1;
            if (done) begin
                done_cnt++; busy_at_done = busy; err_at_done = nack_err;
            end else if (done_cnt > 0) begin
                break;
            end
        end
        req_valid = 1'b0;
    endtask

    task automatic check_good(input logic [6:0] r, input logic [8:0] d);
        chk(rx_n == 3, "R5 byte count", rx_n, 3);
        chk(rx_b[0] == 8'h34, "R2 device byte", rx_b[0], 8'h34);
        chk(rx_b[1] == {r, d[8]}, "R3 index byte", rx_b[1], {r, d[8]});
        chk(rx_b[2] == d[7:0], "R4 low data byte", rx_b[2], d[7:0]);
        chk(start_cnt == 1 && stop_cnt == 1, "R6 one START one STOP", start_cnt * 16 + stop_cnt, 17);
        chk(done_cnt == 1 && !busy_at_done, "R11 done pulse", done_cnt, 1);
        chk(err_at_done == 0, "R8 no error on full ack", err_at_done, 0);
        chk(busy_after_take && !ready_while_busy, "R10 busy after take", busy_after_take, 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(!scl_low && !sda_low, "R1 lines released", {scl_low, sda_low}, 0);
        chk(req_ready && !busy, "R1 ready idle", {req_ready, busy}, 2);
        chk(!nack_err && !done, "R1 no status", {nack_err, done}, 0);
    endtask

    task automatic t_basic();
        run_xfer(7'h29, 9'h008, 9, 0);
        check_good(7'h29, 9'h008);
        chk(rx_b[1] == 8'h52, "R3 example 0x52", rx_b[1], 8'h52);
        chk(period_meas == SCL_T, "R7 scl period", period_meas, SCL_T);
    endtask

    task automatic t_patterns();
        run_xfer(7'h7F, 9'h1FF, 9, 0);
        check_good(7'h7F, 9'h1FF);
        run_xfer(7'h00, 9'h100, 9, 0);
        check_good(7'h00, 9'h100);
        run_xfer(7'h0F, 9'h0A5, 9, 0);
        check_good(7'h0F, 9'h0A5);
        run_xfer(7'h55, 9'h15A, 9, 0);
        check_good(7'h55, 9'h15A);
    endtask

    task automatic t_nack();
        for (int k = 0; k < 3; k++) begin
            run_xfer(7'h34, 9'h1C3, k, 0);
            chk(rx_n == k + 1, "R8 bytes up to nack", rx_n, k + 1);
            chk(stop_cnt == 1 && start_cnt == 1, "R8 stop after nack", stop_cnt, 1);
            chk(done_cnt == 1 && err_at_done && !busy_at_done, "R8 nack reported", err_at_done, 1);
        end
    endtask

    task automatic t_err_hold_clear();
        repeat (100) @(negedge clk);
        chk(nack_err == 1, "R9 error held while idle", nack_err, 1);
        run_xfer(7'h11, 9'h022, 9, 0);
        chk(err_after_take == 0, "R9 error cleared on take", err_after_take, 0);
        check_good(7'h11, 9'h022);
    endtask

    task automatic t_busy_ignore();
        run_xfer(7'h2A, 9'h0F0, 9, 1);
        check_good(7'h2A, 9'h0F0);
        repeat (400) @(negedge clk);
        chk(start_cnt == 1 && !busy, "R10 request while busy ignored", start_cnt, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_patterns();
        t_nack();
        t_err_hold_clear();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule